// File: doc/BRIEF.md
# Transmit Latency Flush Controller

This block sits beside a transmit byte buffer and decides when buffered bytes go to the packet reader that feeds the host. A full packet's worth of data is released at once. A smaller residue is released as a short packet once the buffer has been non-empty and quiet (no new byte, no packet taken) for a software-programmable number of milliseconds.

The block divides its clock down to a millisecond tick, keeps an 8-bit latency register (reset value 16), and raises a flush request that stays up until the packet reader acknowledges it. A side signal tells the reader whether the release is a full packet or a short one.

Top module: `tx_flush_timer`

## Requirements
- R1: After reset `flush_req_o` is 0 and the latency register holds 16, so a lone byte is flushed after 16 ticks.
- R2: A millisecond tick occurs on every CLK_DIV-th clock edge after reset release (edges CLK_DIV, 2*CLK_DIV, ...), independent of other inputs.
- R3: With the buffer non-empty, no restart and no pending request, the N-th tick after the last restart (N = effective latency) raises `flush_req_o` after that edge with `flush_full_o` = 0 (short packet).
- R4: A `byte_wr_i` pulse restarts the latency count; ticks before it do not count.
- R5: A `pkt_done_i` pulse restarts the latency count in the same way.
- R6: While `fill_i` is 0 the count is held at zero and no request is raised; the count starts when the buffer becomes non-empty.
- R7: When `fill_i` is at least PKT_SIZE (64) and no request is pending, `flush_req_o` rises after the next edge with `flush_full_o` = 1, without waiting for a tick.
- R8: A raised request and its kind stay stable until `flush_ack_i` is sampled high; the request then falls after that edge. An acknowledge with no request pending has no effect.
- R9: A write of `cfg_data_i` under `cfg_we_i` sets the latency in ticks for later counts (1 to 255); a written 0 acts as 1.
- R10: When the full-packet condition and a latency expiry hit the same edge, the request is marked full (`flush_full_o` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_wr_i | input | 1 | Pulse: a byte entered the buffer |
| pkt_done_i | input | 1 | Pulse: the reader finished removing a packet |
| fill_i | input | FILL_W | Current buffer fill count in bytes |
| cfg_we_i | input | 1 | Latency register write strobe |
| cfg_data_i | input | TO_W | Latency value in milliseconds |
| flush_ack_i | input | 1 | Reader accepts the pending request |
| flush_req_o | output | 1 | Flush request, held until acknowledged |
| flush_full_o | output | 1 | 1 = full-packet release, 0 = short-packet release |

## Verification
The bench builds the block with CLK_DIV = 4 and the default PKT_SIZE of 64 and 8-bit latency, so one millisecond is four clocks. That brings the default 16 ms latency, the 0-as-1 and 1 ms corners and the 255 ms maximum within a few thousand cycles, and lets each expected flush edge be computed exactly from the tick grid, including an expiry that lands on the same edge as a full-packet fill.

// File: rtl/tx_flush_pkg.sv
package tx_flush_pkg;
  typedef enum logic {
    KIND_SHORT = 1'b0,
    KIND_FULL  = 1'b1
  } flush_kind_e;
endpackage

// File: rtl/tx_ms_prescaler.sv
module tx_ms_prescaler #(
  parameter int unsigned CLK_DIV = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      a_r2_div_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/tx_timeout_cfg.sv
module tx_timeout_cfg #(
  parameter int unsigned TO_W       = 8,
  parameter int unsigned TO_DEFAULT = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [TO_W-1:0] data_i,
  output logic [TO_W-1:0] limit_o
);
  logic [TO_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= TO_W'(TO_DEFAULT);
    else if (we_i) cfg_q <= data_i;
  end

  // zero is folded to the shortest latency
  assign limit_o = (cfg_q == '0) ? TO_W'(1) : cfg_q;

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cfg_q == $past(data_i));
  a_r9_limit_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> limit_o != '0);
endmodule

// File: rtl/tx_latency_timer.sv
module tx_latency_timer #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            restart_i,
  input  logic            empty_i,
  input  logic            hold_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            expire_o
);
  logic [TO_W-1:0] cnt_q;
  logic            idle;

  assign idle     = restart_i | empty_i | hold_i;
  // >= so a lowered limit mid-count still expires
  assign expire_o = tick_i & ~idle & (cnt_q >= limit_i - TO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (idle)     cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  a_r3_clear_after_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == '0);
  a_r6_empty_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |=> cnt_q == '0);
  a_r4_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/tx_flush_arbiter.sv
module tx_flush_arbiter
  import tx_flush_pkg::*;
#(
  parameter int unsigned FILL_W   = 8,
  parameter int unsigned PKT_SIZE = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              expire_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              full_o
);
  localparam logic [FILL_W-1:0] PKT_LVL = FILL_W'(PKT_SIZE);

  logic        req_q;
  flush_kind_e kind_q;
  logic        full_hit;

  assign full_hit = (fill_i >= PKT_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      kind_q <= KIND_SHORT;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (full_hit) begin
      req_q  <= 1'b1;
      kind_q <= KIND_FULL;
    end else if (expire_i) begin
      req_q  <= 1'b1;
      kind_q <= KIND_SHORT;
    end
  end

  assign req_o  = req_q;
  assign full_o = (kind_q == KIND_FULL);

  a_r8_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q && $stable(kind_q));
  a_r8_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && ack_i |=> !req_q);
  a_r7_full_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && full_hit |=> req_q && full_o);
  a_r3_short_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && !full_hit && expire_i |=> req_q && !full_o);
  a_r10_full_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && full_hit && expire_i |=> full_o);
  a_r6_no_rise_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && !full_hit && !expire_i |=> !req_q);
endmodule

// File: rtl/tx_flush_timer.sv
module tx_flush_timer #(
  parameter int unsigned CLK_DIV    = 12000,
  parameter int unsigned FILL_W     = 8,
  parameter int unsigned PKT_SIZE   = 64,
  parameter int unsigned TO_W       = 8,
  parameter int unsigned TO_DEFAULT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_wr_i,
  input  logic              pkt_done_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              cfg_we_i,
  input  logic [TO_W-1:0]   cfg_data_i,
  input  logic              flush_ack_i,
  output logic              flush_req_o,
  output logic              flush_full_o
);
  logic            tick;
  logic            expire;
  logic [TO_W-1:0] limit;

  tx_ms_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  tx_timeout_cfg #(.TO_W(TO_W), .TO_DEFAULT(TO_DEFAULT)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .data_i(cfg_data_i), .limit_o(limit)
  );

  tx_latency_timer #(.TO_W(TO_W)) u_timer (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .restart_i (byte_wr_i | pkt_done_i),
    .empty_i   (fill_i == '0),
    .hold_i    (flush_req_o),
    .limit_i   (limit),
    .expire_o  (expire)
  );

  tx_flush_arbiter #(.FILL_W(FILL_W), .PKT_SIZE(PKT_SIZE)) u_arb (
    .clk_i, .rst_ni,
    .fill_i   (fill_i),
    .expire_i (expire),
    .ack_i    (flush_ack_i),
    .req_o    (flush_req_o),
    .full_o   (flush_full_o)
  );
endmodule

// File: tb/tb_tx_flush_timer.sv
module tb_tx_flush_timer;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_wr = 1'b0, pkt_done = 1'b0, cfg_we = 1'b0, ack = 1'b0;
  logic [7:0] fill = '0, cfg_data = '0;
  logic       req, full;

  int errors = 0, checks = 0, ecnt = 0;
  int  q_edge[$];
  bit  q_full[$];
  string q_tag[$];

  always #2 clk = ~clk;

  tx_flush_timer #(.CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_wr_i(byte_wr), .pkt_done_i(pkt_done),
    .fill_i(fill), .cfg_we_i(cfg_we), .cfg_data_i(cfg_data),
    .flush_ack_i(ack), .flush_req_o(req), .flush_full_o(full)
  );

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // edge of the lim-th tick strictly after edge r
  function automatic int exp_edge(input int r, input int lim);
    return ((r / DIV) + 1) * DIV + (lim - 1) * DIV;
  endfunction

  task automatic push(input int e, input bit f, input string tag);
    q_edge.push_back(e); q_full.push_back(f); q_tag.push_back(tag);
  endtask

  // monitor: scoreboard pop on each rising request
  logic req_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && req && !req_prev) begin
      if (q_edge.size() == 0) begin
        chk(0, "R6 unexpected request", ecnt, -1);
      end else begin
        int e; bit f; string t;
        e = q_edge.pop_front(); f = q_full.pop_front(); t = q_tag.pop_front();
        chk(ecnt == e, {t, " edge"}, ecnt, e);
        chk(full == f, {t, " kind"}, full, f);
      end
    end
    req_prev = req;
  end

  task automatic byte_in(input logic [7:0] f, output int r);
    byte_wr = 1'b1; fill = f; r = ecnt + 1;
    @(negedge clk);
    byte_wr = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] v);
    cfg_we = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // wait for request, check it holds, acknowledge and drain
  task automatic serve(input string tag);
    while (!req) @(negedge clk);
    repeat (2) begin
      @(negedge clk);
      chk(req == 1'b1, {tag, " R8 held"}, req, 1);
    end
    ack = 1'b1; pkt_done = 1'b1; fill = '0;
    @(negedge clk);
    ack = 1'b0; pkt_done = 1'b0;
    chk(req == 1'b0, {tag, " R8 ack drop"}, req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r, r2, e;
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R1 reset req", req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: default latency 16
    byte_in(8'd1, r);
    push(exp_edge(r, 16), 1'b0, "R1 R3 default");
    serve("R3");

    // R4: second byte restarts count
    byte_in(8'd1, r);
    repeat (40) @(negedge clk);
    byte_in(8'd2, r2);
    push(exp_edge(r2, 16), 1'b0, "R4 byte restart");
    serve("R4");

    // R5: packet removal restarts count
    byte_in(8'd5, r);
    repeat (30) @(negedge clk);
    pkt_done = 1'b1; fill = 8'd3; r2 = ecnt + 1;
    @(negedge clk);
    pkt_done = 1'b0;
    push(exp_edge(r2, 16), 1'b0, "R5 pkt restart");
    serve("R5");

    // R6: empty buffer never flushes
    repeat (100) @(negedge clk);
    chk(req == 1'b0, "R6 empty idle", req, 0);
    // R6: count starts when fill becomes nonzero
    r = ecnt; fill = 8'd3;
    push(exp_edge(r, 16), 1'b0, "R6 start on fill");
    serve("R6");

    // R9: latency 3, 0 as 1, 255
    cfg_wr(8'd3);
    byte_in(8'd1, r);
    push(exp_edge(r, 3), 1'b0, "R9 limit 3");
    serve("R9a");
    cfg_wr(8'd0);
    byte_in(8'd1, r);
    push(exp_edge(r, 1), 1'b0, "R9 zero as one");
    serve("R9b");
    cfg_wr(8'd255);
    byte_in(8'd1, r);
    push(exp_edge(r, 255), 1'b0, "R9 limit 255");
    serve("R9c");

    // R7: full packet released at once
    byte_in(8'd63, r);
    byte_in(8'd64, r);
    push(r, 1'b1, "R7 full packet");
    serve("R7");

    // R10: full and expiry on same edge
    cfg_wr(8'd1);
    byte_in(8'd5, r);
    e = exp_edge(r, 1);
    while (ecnt != e - 1) @(negedge clk);
    fill = 8'd64;
    push(e, 1'b1, "R10 full priority");
    serve("R10");

    // R8: stray ack has no effect
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R8 stray ack", req, 0);

    repeat (10) @(negedge clk);
    chk(q_edge.size() == 0, "R3 all flushes seen", q_edge.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule